// File: doc/BRIEF.md
# DMA Channel Status Register

This block holds the 32-bit status and error word of one host-to-card scatter-gather DMA channel. The engine reports events and bus errors as one-cycle pulses; the block latches each into its own sticky bit, where software reads it and clears it by writing a 1. Four of the event bits (descriptor stopped, descriptor completed, bad magic, stopped-to-idle) latch only while their interrupt-enable control input is high. The two descriptor sanity errors, the three error fields and the link-down bit latch unconditionally.

Every sticky bit also clears on the cycle the channel's Run control input goes from 0 to 1. This lets a restarted channel begin with a clean word and needs no separate software write. Bit 0 is not stored: it shows the engine's busy input live. The interrupt output is high while any stored bit is 1. The read port is a plain combinational view of the word, so reading has no side effects. When an event and a clear reach the same bit in the same cycle, the event wins, so no event is lost.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, rd_data_o is 0x00000000 and irq_o is 0.
- R2: rd_data_o[0] follows busy_i in the same cycle and keeps no history.
- R3: Bits 1 (stop descriptor done), 2 (complete descriptor done), 4 (bad magic) and 6 (stopped to idle) set on the clock edge after their event pulse only if the matching enable (ie_stop_i, ie_cmpl_i, ie_magic_i, ie_idle_i) is high in that cycle; otherwise the bit stays unchanged.
- R4: Bit 3 (address misalignment) and bit 5 (length not a multiple of stream width) set on any event pulse, with no enable.
- R5: rd_err_i[k] sets bit 9+k and fetch_err_i[k] sets bit 19+k for k = 0..4. The order is unsupported request (k=0), completer abort, parity error, poisoned header, unexpected completion (k=4).
- R6: wr_err_i[0] (decode error) sets bit 14, wr_err_i[1] (slave error) sets bit 15, and link_down_i sets bit 24. Bits 18:16, 8:7 and 31:25 always read 0.
- R7: A write with wr_en_i high clears every sticky bit whose wr_data_i bit is 1 on that edge. Bits written with 0 keep their value.
- R8: On the edge where run_i is first seen 1 after being 0, all sticky bits clear. Run staying high or falling clears nothing.
- R9: If a set pulse and a clear (write-1 or Run rising) hit the same bit in the same cycle, the bit ends up 1.
- R10: irq_o is 1 exactly while any sticky bit (bits 24:1) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Write data; 1 bits clear sticky bits |
| rd_data_o | output | 32 | Current status word |
| run_i | input | 1 | Channel Run control bit level |
| ie_stop_i | input | 1 | Enable for descriptor-stopped latch |
| ie_cmpl_i | input | 1 | Enable for descriptor-completed latch |
| ie_magic_i | input | 1 | Enable for bad-magic latch |
| ie_idle_i | input | 1 | Enable for stopped-to-idle latch |
| busy_i | input | 1 | Engine busy level |
| evt_stop_i | input | 1 | Descriptor with STOP flag finished |
| evt_cmpl_i | input | 1 | Descriptor with COMPLETE flag finished |
| evt_align_i | input | 1 | Source/destination misalignment |
| evt_magic_i | input | 1 | Stopped on invalid descriptor magic |
| evt_len_i | input | 1 | Length not a multiple of stream width |
| evt_idle_i | input | 1 | Engine went idle after Run cleared |
| rd_err_i | input | 5 | Read error pulses |
| wr_err_i | input | 2 | Write error pulses (decode, slave) |
| fetch_err_i | input | 5 | Descriptor fetch error pulses |
| link_down_i | input | 1 | Link-down pulse |
| irq_o | output | 1 | Any sticky bit set |

## Verification
A stored bit in a wrong state is visible on rd_data_o on the cycle after the faulty edge, and the same edge also moves irq_o if the word becomes empty or non-empty. Wrong gating, a wrong field position, or a lost set under a colliding clear each show as one wrong bit in the word read right after the stimulus edge. A Run-edge clear that fires at the wrong time shows as stored bits vanishing, or surviving, on the edge after run_i changes.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int REG_W      = 32;
  localparam int ERR_W      = 5;
  localparam int WR_ERR_W   = 2;
  localparam int BUSY_BIT   = 0;
  localparam int STOP_BIT   = 1;
  localparam int CMPL_BIT   = 2;
  localparam int ALIGN_BIT  = 3;
  localparam int MAGIC_BIT  = 4;
  localparam int LEN_BIT    = 5;
  localparam int IDLE_BIT   = 6;
  localparam int RD_LSB     = 9;
  localparam int WR_LSB     = 14;
  localparam int FETCH_LSB  = 19;
  localparam int LINK_BIT   = 24;

  function automatic logic [REG_W-1:0] field_mask(input int lsb, input int w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] STICKY_MASK =
      field_mask(STOP_BIT, IDLE_BIT - STOP_BIT + 1) |
      field_mask(RD_LSB, ERR_W) |
      field_mask(WR_LSB, WR_ERR_W) |
      field_mask(FETCH_LSB, ERR_W) |
      field_mask(LINK_BIT, 1);
endpackage

// File: rtl/dma_stat_run_edge.sv
module dma_stat_run_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic rise_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_i;
  end

  assign rise_o = run_i & ~run_q;

  assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dma_stat_evt_map.sv
module dma_stat_evt_map
  import dma_stat_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ie_stop_i,
  input  logic                ie_cmpl_i,
  input  logic                ie_magic_i,
  input  logic                ie_idle_i,
  input  logic                evt_stop_i,
  input  logic                evt_cmpl_i,
  input  logic                evt_align_i,
  input  logic                evt_magic_i,
  input  logic                evt_len_i,
  input  logic                evt_idle_i,
  input  logic [ERR_W-1:0]    rd_err_i,
  input  logic [WR_ERR_W-1:0] wr_err_i,
  input  logic [ERR_W-1:0]    fetch_err_i,
  input  logic                link_down_i,
  output logic [REG_W-1:0]    set_o
);
  always_comb begin
    set_o            = '0;
    set_o[STOP_BIT]  = evt_stop_i  & ie_stop_i;
    set_o[CMPL_BIT]  = evt_cmpl_i  & ie_cmpl_i;
    set_o[ALIGN_BIT] = evt_align_i;
    set_o[MAGIC_BIT] = evt_magic_i & ie_magic_i;
    set_o[LEN_BIT]   = evt_len_i;
    set_o[IDLE_BIT]  = evt_idle_i  & ie_idle_i;
    for (int k = 0; k < ERR_W; k++) begin
      set_o[RD_LSB+k]    = rd_err_i[k];
      set_o[FETCH_LSB+k] = fetch_err_i[k];
    end
    for (int k = 0; k < WR_ERR_W; k++) set_o[WR_LSB+k] = wr_err_i[k];
    set_o[LINK_BIT]  = link_down_i;
  end

  // gated events never reach the bank without their enable
  assert_gate_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_stop_i |-> !set_o[STOP_BIT]);
  assert_gate_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_idle_i |-> !set_o[IDLE_BIT]);
  assert_no_stray_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o & ~STICKY_MASK) == '0);
endmodule

// File: rtl/dma_stat_sticky_bank.sv
module dma_stat_sticky_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_r <= 1'b0;
      else if (set_i[k])  q_r <= 1'b1;   // set beats clear
      else if (clr_i[k])  q_r <= 1'b0;
    end
    assign q_o[k] = q_r;

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
    assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !q_o[k]);
    assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && !set_i[k]) |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        run_i,
  input  logic        ie_stop_i,
  input  logic        ie_cmpl_i,
  input  logic        ie_magic_i,
  input  logic        ie_idle_i,
  input  logic        busy_i,
  input  logic        evt_stop_i,
  input  logic        evt_cmpl_i,
  input  logic        evt_align_i,
  input  logic        evt_magic_i,
  input  logic        evt_len_i,
  input  logic        evt_idle_i,
  input  logic [4:0]  rd_err_i,
  input  logic [1:0]  wr_err_i,
  input  logic [4:0]  fetch_err_i,
  input  logic        link_down_i,
  output logic        irq_o
);
  logic [REG_W-1:0] set_vec, clr_vec, sticky_q;
  logic             run_rise;

  dma_stat_run_edge u_run_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .rise_o (run_rise)
  );

  dma_stat_evt_map u_evt_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ie_stop_i   (ie_stop_i),
    .ie_cmpl_i   (ie_cmpl_i),
    .ie_magic_i  (ie_magic_i),
    .ie_idle_i   (ie_idle_i),
    .evt_stop_i  (evt_stop_i),
    .evt_cmpl_i  (evt_cmpl_i),
    .evt_align_i (evt_align_i),
    .evt_magic_i (evt_magic_i),
    .evt_len_i   (evt_len_i),
    .evt_idle_i  (evt_idle_i),
    .rd_err_i    (rd_err_i),
    .wr_err_i    (wr_err_i),
    .fetch_err_i (fetch_err_i),
    .link_down_i (link_down_i),
    .set_o       (set_vec)
  );

  assign clr_vec = ((wr_en_i ? wr_data_i : '0) | {REG_W{run_rise}}) & STICKY_MASK;

  dma_stat_sticky_bank #(.W(REG_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .q_o    (sticky_q)
  );

  always_comb begin
    rd_data_o           = sticky_q & STICKY_MASK;
    rd_data_o[BUSY_BIT] = busy_i;
  end

  assign irq_o = |(sticky_q & STICKY_MASK);

  assert_run_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_rise && set_vec == '0) |=> rd_data_o[31:1] == '0);
  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(set_vec != '0));
  assert_gate_cmpl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_cmpl_i && !rd_data_o[CMPL_BIT]) |=> !rd_data_o[CMPL_BIT]);
  assert_busy_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BUSY_BIT] == busy_i);
endmodule

// File: tb/dma_chan_status_tb.sv
module dma_chan_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        run = 1'b0;
  logic [3:0]  ie = '0;
  logic        busy = 1'b0;
  logic [31:0] ev = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  logic        irq_q[$];
  string       tag_q[$];

  logic [31:0] model = '0;
  logic        run_prev = 1'b0;
  localparam logic [31:0] TB_STICKY = 32'h0000_007E | 32'h0000_FE00 | 32'h01F8_0000;

  always #2 clk = ~clk;  // 250 MHz

  dma_chan_status u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_data_o (rd_data),
    .run_i (run),
    .ie_stop_i (ie[0]), .ie_cmpl_i (ie[1]), .ie_magic_i (ie[2]), .ie_idle_i (ie[3]),
    .busy_i (busy),
    .evt_stop_i (ev[1]), .evt_cmpl_i (ev[2]), .evt_align_i (ev[3]),
    .evt_magic_i (ev[4]), .evt_len_i (ev[5]), .evt_idle_i (ev[6]),
    .rd_err_i (ev[13:9]), .wr_err_i (ev[15:14]), .fetch_err_i (ev[23:19]),
    .link_down_i (ev[24]),
    .irq_o (irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, predict, push expectation
  task automatic step(input logic [31:0] e, input logic we, input logic [31:0] wd,
                      input logic r, input logic [3:0] en, input logic b, input string tag);
    logic [31:0] g, clr;
    @(negedge clk); #1;
    ev = e; wr_en = we; wr_data = wd; run = r; ie = en; busy = b;
    @(posedge clk); #1;
    g = e & TB_STICKY;
    if (!en[0]) g[1] = 1'b0;
    if (!en[1]) g[2] = 1'b0;
    if (!en[2]) g[4] = 1'b0;
    if (!en[3]) g[6] = 1'b0;
    clr = (we ? wd : 32'h0) | ((r && !run_prev) ? 32'hFFFF_FFFF : 32'h0);
    model = (g | (model & ~clr)) & TB_STICKY;
    run_prev = r;
    exp_q.push_back(model | {31'b0, b});
    irq_q.push_back(model != 0);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      logic        ei;
      string       t;
      e = exp_q.pop_front(); ei = irq_q.pop_front(); t = tag_q.pop_front();
      check({t, " word"}, rd_data, e);
      check({t, " irq R10"}, {31'b0, irq}, {31'b0, ei});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    step('0, 0, '0, 0, 4'h0, 1, "R2 busy high");
    step('0, 0, '0, 0, 4'h0, 0, "R2 busy low");

    step(32'h56, 0, '0, 0, 4'h0, 0, "R3 gated off");
    step(32'h02, 0, '0, 0, 4'h1, 0, "R3 stop enabled");
    step(32'h04, 0, '0, 0, 4'h2, 0, "R3 cmpl enabled");
    step(32'h10, 0, '0, 0, 4'h4, 0, "R3 magic enabled");
    step(32'h40, 0, '0, 0, 4'h8, 0, "R3 idle enabled");

    step('0, 1, 32'h0000_0000, 0, 4'h0, 0, "R7 write zero no effect");
    step('0, 1, 32'h0000_0006, 0, 4'h0, 1, "R7 clear 2 and 1");
    step('0, 1, 32'hFFFF_FFFF, 0, 4'h0, 0, "R7 clear all");

    step(32'h08, 0, '0, 0, 4'h0, 0, "R4 align ungated");
    step(32'h20, 0, '0, 0, 4'h0, 0, "R4 len ungated");
    step('0, 1, 32'h28, 0, 4'h0, 0, "R7 clear 5 and 3");

    step(32'h0000_0200, 0, '0, 0, 4'h0, 0, "R5 read unsupported request");
    step(32'h0000_2000, 0, '0, 0, 4'h0, 0, "R5 read unexpected completion");
    step(32'h0020_0000, 0, '0, 0, 4'h0, 0, "R5 fetch parity");
    step(32'h0000_8000, 0, '0, 0, 4'h0, 0, "R6 write slave error");
    step(32'h0000_4000, 0, '0, 0, 4'h0, 0, "R6 write decode error");
    step(32'h0100_0000, 0, '0, 0, 4'h0, 0, "R6 link down");
    step('0, 1, 32'h0000_0000, 0, 4'h0, 0, "R6 reserved bits zero");

    step('0, 0, '0, 1, 4'h0, 0, "R8 run rise clears");
    step(32'h08, 0, '0, 1, 4'h0, 0, "R8 run held set");
    step('0, 0, '0, 1, 4'h0, 0, "R8 run held no clear");
    step('0, 0, '0, 0, 4'h0, 0, "R8 run fall no clear");
    step('0, 0, '0, 1, 4'h0, 0, "R8 run rise again clears");

    step(32'h0100_0000, 0, '0, 1, 4'h0, 0, "R9 prep link");
    step(32'h0100_0000, 1, 32'h0100_0000, 1, 4'h0, 0, "R9 set beats write clear");
    step('0, 0, '0, 0, 4'h0, 0, "R9 run low");
    step(32'h0000_0020, 0, '0, 1, 4'h0, 0, "R9 set beats run clear");
    step('0, 1, 32'hFFFF_FFFF, 1, 4'h0, 0, "R10 irq drops on empty");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule